// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block programs a target FPGA over a slave-serial link from a byte stream. Bytes arrive on a valid/ready input. Leading file bytes are discarded until the first 0xFF sync byte. The next four bytes form a tagged header that carries a 24-bit configuration bit count. The loader then pulses the target's active-low program pin and waits a clear interval. It checks that the status pin reads low, and after that shifts every byte from the sync byte onward onto the data line, most significant bit first, with a generated configuration clock.

After the last byte the loader waits a settle interval and checks that the status pin reads high. Each failure stops the run with its own error code. Both intervals count pulses of a tick-enable input, so the same block runs with real millisecond delays on silicon and with short delays in simulation. A run begins only on a start pulse.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After a start pulse, input bytes before the first 0xFF are consumed and dropped. The first byte shifted to the target is that 0xFF, and every later stream byte follows it in order.
- R2: The byte after the sync byte must have upper nibble 0x2. Any other value ends the run with error code 2 before the program pin is pulsed.
- R3: The bit count is {tag[3:0], byte2, byte3, byte4[7:4]}, where the bytes follow the sync byte. If the number of bytes from the sync byte to the end of the stream, both included, is less than bit count / 8, the run ends with error code 3. A stream that ends on or inside the header also gives code 3.
- R4: If the stream ends (last flag) before any 0xFF is seen, the run ends with error code 1.
- R5: Chip select is asserted whenever the program pin is low. The program pin is driven low for exactly one cycle. No configuration clock edge occurs until CLR_TICKS tick pulses have elapsed after the pin is released.
- R6: When the clear interval ends, a high status input ends the run with error code 4, and no clock edge is produced.
- R7: Each bit is sent MSB first over four cycles with the clock low, high, high, low. Data is held stable while the clock is high. Consecutive bits of a byte start four cycles apart.
- R8: After the last bit, SETTLE_TICKS tick pulses are waited. A high status input then raises done with no error. A low status input raises error code 5. Done and error are never both high.
- R9: After an error or success the block is idle: program pin high, chip select low, clock low, and done/error/code held. Nothing changes until the next start pulse, which begins a fresh run.
- R10: Ready is high only while scanning or header collection is in progress, or while streaming with the shifter free. It is never high while the program pin is low or after the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable for the delay intervals |
| start_i | input | 1 | Start pulse, sampled only when idle |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_last_i | input | 1 | Marks the final stream byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| stat_i | input | 1 | Target status pin (low = busy/clearing, high = configured) |
| prog_no | output | 1 | Active-low program pin |
| cs_o | output | 1 | Chip-select for the target's configuration pins |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration data |
| done_o | output | 1 | Run finished successfully |
| err_o | output | 1 | Run ended with an error |
| err_code_o | output | 3 | 1 no sync, 2 bad tag, 3 too short, 4 clear not acknowledged, 5 still busy |

## Verification
The main stream test puts garbage before the sync byte and uses a bit count that exactly matches the stream length. This shows that the scan drops bytes, and it checks the length boundary from the passing side. Removing one byte, or setting the tag's low nibble so that the count becomes huge, must give the too-short code; this shows that the count is assembled from the right nibbles. The received bytes are rebuilt from clock edges and include asymmetric patterns such as 0x01 and 0x80, which separate MSB-first from LSB-first order. Status-pin scenarios held high from the start, or never rising, separate the two status checks from each other and from the parse errors.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  localparam int BITCNT_W  = 24;
  localparam int HDR_BYTES = 5;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] TAG_NIB   = 4'h2;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NO_SYNC  = 3'd1,
    ERR_BAD_TAG  = 3'd2,
    ERR_SHORT    = 3'd3,
    ERR_CLR_NACK = 3'd4,
    ERR_BUSY     = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_HDR, ST_PROG, ST_CLR, ST_FEED, ST_SETTLE
  } st_e;
endpackage

// File: rtl/cfg_ld_delay.sv
module cfg_ld_delay #(
  parameter int CLR_TICKS    = 50000,
  parameter int SETTLE_TICKS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_clr_i,
  input  logic arm_settle_i,
  output logic expired_o
);
  localparam int MAXT = (CLR_TICKS > SETTLE_TICKS) ? CLR_TICKS : SETTLE_TICKS;
  localparam int W    = $clog2(MAXT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (arm_clr_i)     cnt_q <= W'(CLR_TICKS);
    else if (arm_settle_i)  cnt_q <= W'(SETTLE_TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_ld_shifter.sv
module cfg_ld_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       din_o
);
  logic       active_q;
  logic [7:0] sh_q;
  logic [2:0] bit_q;
  logic [1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (!active_q) begin
      if (load_i) begin
        active_q <= 1'b1;
        sh_q     <= byte_i;
        bit_q    <= 3'd7;
        slot_q   <= 2'd0;
      end
    end else begin
      slot_q <= slot_q + 2'd1;
      if (slot_q == 2'd3) begin
        if (bit_q == 3'd0) active_q <= 1'b0;
        else               bit_q    <= bit_q - 3'd1;
      end
    end
  end

  // slots: 0 setup (low), 1-2 high, 3 low
  assign cclk_o = active_q && (slot_q == 2'd1 || slot_q == 2'd2);
  assign din_o  = sh_q[bit_q];
  assign idle_o = !active_q;
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int CLR_TICKS    = 50000,
  parameter int SETTLE_TICKS = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       stat_i,
  output logic       prog_no,
  output logic       cs_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       done_o,
  output logic       err_o,
  output logic [2:0] err_code_o
);
  localparam logic [2:0] HDR_N = 3'(HDR_BYTES);

  st_e                 st_q;
  logic [7:0]          hdr_q [HDR_BYTES];
  logic [2:0]          hidx_q, fidx_q;
  logic [BITCNT_W-1:0] nbytes_q;
  logic                end_q, done_q, err_q;
  err_e                code_q;

  logic                sh_idle, sh_load;
  logic [7:0]          sh_byte;
  logic                arm_clr, arm_settle, expired;
  logic                hs;
  logic [BITCNT_W-1:0] need, need_hdr;

  // R3: bit count from tag low nibble, two bytes, high nibble of last header byte
  assign need     = {hdr_q[1][3:0], hdr_q[2], hdr_q[3], hdr_q[4][7:4]} >> 3;
  assign need_hdr = {hdr_q[1][3:0], hdr_q[2], hdr_q[3], s_data_i[7:4]} >> 3;

  // R10
  assign s_ready_o = (st_q == ST_SCAN) || (st_q == ST_HDR) ||
                     (st_q == ST_FEED && sh_idle && fidx_q == HDR_N && !end_q);
  assign hs = s_ready_o && s_valid_i;

  always_comb begin
    sh_load = 1'b0;
    sh_byte = s_data_i;
    if (st_q == ST_FEED && sh_idle) begin
      if (fidx_q < HDR_N) begin
        sh_load = 1'b1;
        sh_byte = hdr_q[fidx_q];
      end else if (!end_q && s_valid_i) begin
        sh_load = 1'b1;
      end
    end
  end

  assign arm_clr    = (st_q == ST_PROG);
  assign arm_settle = (st_q == ST_FEED) && sh_idle && fidx_q == HDR_N && end_q &&
                      !(nbytes_q < need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= '0;
      hidx_q   <= '0;
      fidx_q   <= '0;
      nbytes_q <= '0;
      end_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= ERR_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SCAN;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          code_q <= ERR_NONE;
          end_q  <= 1'b0;
        end
        ST_SCAN: if (hs) begin                      // R1, R4
          if (s_data_i == SYNC_BYTE) begin
            hdr_q[0] <= s_data_i;
            hidx_q   <= 3'd1;
            if (s_last_i) begin
              st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_SHORT;
            end else st_q <= ST_HDR;
          end else if (s_last_i) begin
            st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_NO_SYNC;
          end
        end
        ST_HDR: if (hs) begin                       // R2, R3
          hdr_q[hidx_q] <= s_data_i;
          hidx_q        <= hidx_q + 3'd1;
          if (hidx_q == 3'd1 && s_data_i[7:4] != TAG_NIB) begin
            st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_BAD_TAG;
          end else if (s_last_i) begin
            end_q <= 1'b1;
            if (hidx_q != HDR_N - 3'd1 || BITCNT_W'(HDR_BYTES) < need_hdr) begin
              st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_SHORT;
            end else st_q <= ST_PROG;
          end else if (hidx_q == HDR_N - 3'd1) st_q <= ST_PROG;
        end
        ST_PROG: st_q <= ST_CLR;                    // R5
        ST_CLR: if (expired) begin                  // R6
          if (stat_i) begin
            st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_CLR_NACK;
          end else begin
            st_q     <= ST_FEED;
            fidx_q   <= '0;
            nbytes_q <= '0;
          end
        end
        ST_FEED: begin
          if (sh_load) begin
            nbytes_q <= nbytes_q + 1'b1;
            if (fidx_q < HDR_N) fidx_q <= fidx_q + 3'd1;
            else if (s_last_i)  end_q  <= 1'b1;
          end else if (sh_idle && fidx_q == HDR_N && end_q) begin
            if (nbytes_q < need) begin              // R3
              st_q <= ST_IDLE; err_q <= 1'b1; code_q <= ERR_SHORT;
            end else st_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (expired) begin               // R8
          st_q <= ST_IDLE;
          if (stat_i) done_q <= 1'b1;
          else begin err_q <= 1'b1; code_q <= ERR_BUSY; end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  cfg_ld_delay #(.CLR_TICKS(CLR_TICKS), .SETTLE_TICKS(SETTLE_TICKS)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .arm_clr_i(arm_clr), .arm_settle_i(arm_settle), .expired_o(expired)
  );

  cfg_ld_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .byte_i(sh_byte),
    .idle_o(sh_idle), .cclk_o(cclk_o), .din_o(din_o)
  );

  assign prog_no    = (st_q != ST_PROG);
  assign cs_o       = (st_q == ST_PROG) || (st_q == ST_CLR) ||
                      (st_q == ST_FEED) || (st_q == ST_SETTLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/cfg_ld_chk.sv
module cfg_ld_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       s_ready_o,
  input logic       prog_no,
  input logic       cs_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       done_o,
  input logic       err_o,
  input logic [2:0] err_code_o
);
  AST_PROG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_no) |=> prog_no); // R5
  AST_PROG_WITH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> cs_o); // R5
  AST_CCLK_TWO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |=> cclk_o ##1 !cclk_o); // R7
  AST_DIN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> $stable(din_o)); // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !cclk_o); // R9
  AST_ERR_CODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 3'd0); // R9
  AST_READY_PROG_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> prog_no && !done_o && !err_o); // R10
endmodule

bind fpga_cfg_loader cfg_ld_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_ready_o(s_ready_o), .prog_no(prog_no),
  .cs_o(cs_o), .cclk_o(cclk_o), .din_o(din_o), .done_o(done_o),
  .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;
  localparam int CLR_T = 8;
  localparam int SET_T = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_valid_i = 1'b0, s_last_i = 1'b0, stat_i = 1'b0;
  logic s_ready_o, prog_no, cs_o, cclk_o, din_o, done_o, err_o;
  logic [2:0] err_code_o;

  always #2 clk_i = ~clk_i;

  fpga_cfg_loader #(.CLR_TICKS(CLR_T), .SETTLE_TICKS(SET_T)) u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] stim [64];
  int n_stim, acc;
  logic stat_init, stat_final;
  int stat_bits;

  logic [7:0] rcv [64];
  logic [7:0] bitacc;
  int nrise, prog_lo, t_rel, t_r0, t_r1, rdy_bad, cyc;
  logic cclk_q, prog_q;

  task automatic clear_mon();
    nrise = 0; prog_lo = 0; t_rel = 0; t_r0 = 0; t_r1 = 0; rdy_bad = 0;
  endtask

  initial begin
    cyc = 0; cclk_q = 0; prog_q = 1; bitacc = 0; clear_mon();
    stat_init = 0; stat_final = 1; stat_bits = 0;
  end

  always @(negedge clk_i) begin
    cyc++;
    tick_i = ~tick_i;
    if (cclk_o && !cclk_q) begin
      bitacc = {bitacc[6:0], din_o};
      if (nrise % 8 == 7) rcv[nrise / 8] = bitacc;
      if (nrise == 0) t_r0 = cyc;
      if (nrise == 1) t_r1 = cyc;
      nrise++;
    end
    if (!prog_no) prog_lo++;
    if (prog_no && !prog_q) t_rel = cyc;
    if (s_ready_o && !prog_no) rdy_bad++;
    cclk_q = cclk_o; prog_q = prog_no;
    stat_i = (nrise >= stat_bits) ? stat_final : stat_init;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run();
    int g;
    clear_mon();
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
    acc = 0; g = 0;
    while (acc < n_stim && !err_o && g < 5000) begin
      s_valid_i = 1; s_data_i = stim[acc]; s_last_i = (acc == n_stim - 1);
      if (s_ready_o) acc++;
      @(negedge clk_i); g++;
    end
    s_valid_i = 0; s_last_i = 0;
    g = 0;
    while (!done_o && !err_o && g < 3000) begin @(negedge clk_i); g++; end
  endtask

  task automatic load_ok();
    logic [7:0] v [12] = '{8'h12, 8'h00, 8'hAB, 8'hFF, 8'h20, 8'h00, 8'h04, 8'h80,
                           8'hA5, 8'h3C, 8'h01, 8'hF0};
    for (int i = 0; i < 12; i++) stim[i] = v[i];
    n_stim = 12;  // count 0x000048 = 72 bits = 9 bytes from sync
    stat_init = 0; stat_final = 1; stat_bits = 72;
  endtask

  task automatic t_reset();
    check("R9 reset prog", prog_no, 1);
    check("R9 reset cs", cs_o, 0);
    check("R9 reset cclk", cclk_o, 0);
    check("R10 reset ready", s_ready_o, 0);
    check("R8 reset done", {done_o, err_o}, 0);
  endtask

  task automatic t_ok(input string tag);
    logic [7:0] ex [9] = '{8'hFF, 8'h20, 8'h00, 8'h04, 8'h80, 8'hA5, 8'h3C, 8'h01, 8'hF0};
    load_ok();
    run();
    check({tag, " R8 done"}, {done_o, err_o}, 2'b10);
    check("R1 all bytes accepted", acc, 12);
    check("R1 bits shifted", nrise, 72);
    check("R1 first byte is sync", rcv[0], 8'hFF);
    for (int i = 1; i < 9; i++) check("R7 byte msb first", rcv[i], ex[i]);
    check("R5 prog one cycle", prog_lo, 1);
    check("R5 clear gap", (t_r0 - t_rel) >= 2 * (CLR_T - 1), 1);
    check("R7 bit period", t_r1 - t_r0, 4);
    check("R10 ready while prog low", rdy_bad, 0);
    check("R10 ready after done", s_ready_o, 0);
  endtask

  task automatic t_short();
    load_ok(); n_stim = 11;
    run();
    check("R3 too short code", {err_o, err_code_o}, {1'b1, 3'd3});
    check("R3 bits before abort", nrise, 64);
  endtask

  task automatic t_tagnib();
    load_ok(); stim[4] = 8'h21;
    run();
    check("R3 tag low nibble in count", {err_o, err_code_o}, {1'b1, 3'd3});
  endtask

  task automatic t_badtag();
    stim[0] = 8'h05; stim[1] = 8'hFF; stim[2] = 8'h30; stim[3] = 8'h00; n_stim = 4;
    run();
    check("R2 bad tag code", {err_o, err_code_o}, {1'b1, 3'd2});
    check("R2 no prog pulse", prog_lo, 0);
    check("R10 stops at bad tag", acc, 3);
  endtask

  task automatic t_nosync();
    stim[0] = 8'h01; stim[1] = 8'h02; stim[2] = 8'hFE; n_stim = 3;
    run();
    check("R4 no sync code", {err_o, err_code_o}, {1'b1, 3'd1});
  endtask

  task automatic t_hdrcut();
    stim[0] = 8'hFF; stim[1] = 8'h20; n_stim = 2;
    run();
    check("R3 truncated header", {err_o, err_code_o}, {1'b1, 3'd3});
  endtask

  task automatic t_nack();
    load_ok(); stat_init = 1; stat_final = 1;
    run();
    check("R6 clear nack code", {err_o, err_code_o}, {1'b1, 3'd4});
    check("R6 no clock edges", nrise, 0);
  endtask

  task automatic t_busy();
    load_ok(); stat_final = 0;
    run();
    check("R8 still busy code", {err_o, err_code_o}, {1'b1, 3'd5});
    check("R8 all bits sent", nrise, 72);
  endtask

  task automatic t_hold();
    repeat (40) @(negedge clk_i);
    check("R9 error held", {err_o, err_code_o}, {1'b1, 3'd5});
    check("R9 idle pins", {prog_no, cs_o, cclk_o, s_ready_o}, 4'b1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_ok("first");
    t_short();
    t_tagnib();
    t_badtag();
    t_nosync();
    t_hdrcut();
    t_nack();
    t_busy();
    t_hold();
    t_ok("R9 rerun");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule